// File: doc/BRIEF.md
# Performance Monitor Register File

This block is the software-visible register set of a small performance monitor. It is reached through a coprocessor-style request port. Each request names a register by a 4-bit primary index (`crm`) and a 3-bit secondary index (`opc2`). It also says whether it is a read or a write and whether the requester runs at user or privileged level. One cycle later the block returns a response. The response carries read data or an undefined-instruction trap flag.

The register set has these registers:

- A control word that resets from the top byte of an identification input.
- A counter-enable word, reached through separate set and clear views.
- An overflow status word. Software clears it by writing ones. Hardware inputs set it.
- An event-type byte.
- A user-enable bit.
- Several slots that read as zero and ignore writes.

User-level code may reach the monitor only while the user-enable bit is set. This check covers every register except the user-enable register, and it also covers the constant and unimplemented slots. Event counting itself is not part of this block.

Top module: `pmu_regfile`

## Requirements
- R1: Each request seen with `req_valid` high produces `rsp_valid` high on exactly the next cycle, and `rsp_valid` is low otherwise. `rsp_undef` is high only together with `rsp_valid`. A write that does not trap returns zero read data.
- R2: A request with `req_user`=1 to any register other than user-enable traps when the stored user-enable bit is 0. Privileged requests are never trapped by this check.
- R3: The user-enable register sits at crm=14, opc2=0 and stores only write-data bit 0. Reads return it in bit 0. A user read is always allowed, a user write always traps, and privileged reads and writes are allowed.
- R4: A trapped request modifies no register, and its response carries `rsp_rdata`=0.
- R5: The control register sits at crm=12, opc2=0. Reset loads it with `id_code & 32'hFF000000`. A write changes only the bits in mask 32'h00000039, and every other bit keeps its value.
- R6: A write to crm=12, opc2=1 ORs `wdata & 32'h80000000` into the enable word. A write to crm=12, opc2=2 clears the bits of `wdata & 32'h80000000`. A read of either index returns the same enable word.
- R7: The overflow status register sits at crm=12, opc2=3. Each 1 in the write data clears the matching status bit, and each 0 leaves that bit unchanged.
- R8: `cnt_ovf_set[i]` sets overflow bit i, and `cyc_ovf_set` sets overflow bit 31. Either input takes effect at the next clock edge, even if the request traps. A hardware set wins over a software clear of the same bit in the same cycle.
- R9: The event-type register sits at crm=13, opc2=1. It stores write-data bits [7:0], and bits [31:8] read as zero.
- R10: crm=12/opc2=5, crm=13/opc2=0 and crm=13/opc2=2 read as zero and ignore writes, but remain subject to the R2 check.
- R11: crm=12, opc2=4 accepts writes with no effect on any register. A read of it traps at any privilege level.
- R12: Any crm/opc2 pair not named in R3, R5, R6, R7, R9, R10 or R11 traps for both reads and writes at any privilege level.
- R13: After reset the enable, overflow, event-type and user-enable registers all read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_code | input | 32 | Identification word; its top byte seeds the control register at reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = privileged |
| req_crm | input | 4 | Primary register index |
| req_opc2 | input | 3 | Secondary register index |
| req_wdata | input | 32 | Write data |
| cnt_ovf_set | input | NUM_CNT | Hardware set of overflow bits [NUM_CNT-1:0] |
| cyc_ovf_set | input | 1 | Hardware set of overflow bit 31 |
| rsp_valid | output | 1 | Response present |
| rsp_undef | output | 1 | Undefined-instruction trap for the responded request |
| rsp_rdata | output | 32 | Read data, zero on traps and writes |

## Verification
The bound checker tests several rules on every cycle:

- Response timing follows the request.
- A trap carries zero data.
- A trapped response coincides with unchanged control, enable and user-enable state.
- A user request while user-enable is clear always traps.
- The non-writable control bits never move after reset.
- A hardware overflow set always lands.

Only the bench's scenarios can show the register contents themselves. These include the masking of each write, the set/clear aliasing, write-one-to-clear, and the constant slots reading zero. The bench shows them by sweeping every crm/opc2 pair under both privilege levels, both directions and both user-enable states, and by comparing each response against an arithmetic model.

// File: rtl/pmu_regs_pkg.sv
// Package: shared constants and the register-select type for the
// performance monitor register file. Assumes a 32-bit data path.
package pmu_regs_pkg;

    localparam int DATA_W = 32;
    localparam int CRM_W  = 4;
    localparam int OPC_W  = 3;

    // Index groups that carry registers
    localparam logic [CRM_W-1:0] CRM_MAIN = 4'd12;
    localparam logic [CRM_W-1:0] CRM_EVT  = 4'd13;
    localparam logic [CRM_W-1:0] CRM_PRIV = 4'd14;

    // Write and reset masks
    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0000_0039;
    localparam logic [DATA_W-1:0] CTRL_RMASK = 32'hFF00_0000;
    localparam logic [DATA_W-1:0] EN_WMASK   = 32'h8000_0000;

    typedef enum logic [3:0] {
        SEL_CTRL,
        SEL_ENSET,
        SEL_ENCLR,
        SEL_OVF,
        SEL_SWINC,
        SEL_SELECT,
        SEL_CYC,
        SEL_EVCNT,
        SEL_EVTYPE,
        SEL_UEN,
        SEL_NONE
    } pmu_sel_e;

endpackage

// File: rtl/pmu_decode.sv
// Module: maps a crm/opc2 pair onto a register select.
// Assumes nothing about privilege; unlisted pairs map to SEL_NONE.
module pmu_decode
    import pmu_regs_pkg::*;
(
    input  logic [CRM_W-1:0] crm,
    input  logic [OPC_W-1:0] opc2,
    output pmu_sel_e         sel
);

    // Purpose: combinational index decode
    always_comb begin
        sel = SEL_NONE;
        unique case (crm)
            CRM_MAIN: begin
                case (opc2)
                    3'd0:    sel = SEL_CTRL;
                    3'd1:    sel = SEL_ENSET;
                    3'd2:    sel = SEL_ENCLR;
                    3'd3:    sel = SEL_OVF;
                    3'd4:    sel = SEL_SWINC;
                    3'd5:    sel = SEL_SELECT;
                    default: sel = SEL_NONE;
                endcase
            end
            CRM_EVT: begin
                case (opc2)
                    3'd0:    sel = SEL_CYC;
                    3'd1:    sel = SEL_EVTYPE;
                    3'd2:    sel = SEL_EVCNT;
                    default: sel = SEL_NONE;
                endcase
            end
            CRM_PRIV: begin
                if (opc2 == 3'd0) sel = SEL_UEN;
            end
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/pmu_access_check.sv
// Module: decides whether a request traps as undefined.
// Assumes sel comes from pmu_decode and uen is the stored user-enable bit.
module pmu_access_check
    import pmu_regs_pkg::*;
(
    input  pmu_sel_e sel,
    input  logic     is_write,
    input  logic     is_user,
    input  logic     uen,
    output logic     trap
);

    // Purpose: combine encoding, direction and privilege rules into one trap
    always_comb begin
        trap = 1'b0;
        if (sel == SEL_NONE) begin
            trap = 1'b1;
        end else if (sel == SEL_SWINC && !is_write) begin
            trap = 1'b1;
        end else if (sel == SEL_UEN) begin
            trap = is_user && is_write;
        end else begin
            trap = is_user && !uen;
        end
    end

endmodule

// File: rtl/pmu_state.sv
// Module: holds the architectural registers and applies accepted writes
// and hardware overflow sets. Assumes wr_en is already cleared on traps.
module pmu_state
    import pmu_regs_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int EVT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] id_code,
    input  logic              wr_en,
    input  pmu_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CNT-1:0] cnt_ovf_set,
    input  logic              cyc_ovf_set,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] ovf_q,
    output logic [EVT_W-1:0]  evt_q,
    output logic              uen_q
);

    localparam int CYC_BIT = DATA_W - 1;

    logic [DATA_W-1:0] hw_set;
    logic [DATA_W-1:0] sw_clr;

    // Purpose: spread the hardware set inputs onto overflow bit positions
    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_hwset
            if (gi < NUM_CNT) begin : g_cnt
                assign hw_set[gi] = cnt_ovf_set[gi];
            end else if (gi == CYC_BIT) begin : g_cyc
                assign hw_set[gi] = cyc_ovf_set;
            end else begin : g_none
                assign hw_set[gi] = 1'b0;
            end
        end
    endgenerate

    // Purpose: software clear vector for the overflow word
    always_comb begin
        sw_clr = (wr_en && sel == SEL_OVF) ? wdata : '0;
    end

    // Purpose: control register, masked writes, reset from identification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= id_code & CTRL_RMASK;
        end else if (wr_en && sel == SEL_CTRL) begin
            ctrl_q <= (ctrl_q & ~CTRL_WMASK) | (wdata & CTRL_WMASK);
        end
    end

    // Purpose: counter-enable word through set and clear views
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && sel == SEL_ENSET) begin
            en_q <= en_q | (wdata & EN_WMASK);
        end else if (wr_en && sel == SEL_ENCLR) begin
            en_q <= en_q & ~(wdata & EN_WMASK);
        end
    end

    // Purpose: overflow status, write-one-to-clear with hardware set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~sw_clr) | hw_set;
        end
    end

    // Purpose: event-type byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else if (wr_en && sel == SEL_EVTYPE) begin
            evt_q <= wdata[EVT_W-1:0];
        end
    end

    // Purpose: user-enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uen_q <= 1'b0;
        end else if (wr_en && sel == SEL_UEN) begin
            uen_q <= wdata[0];
        end
    end

endmodule

// File: rtl/pmu_regfile.sv
// Module: top of the performance monitor register file. Accepts one
// request per cycle and answers on the next cycle with data or a trap.
// Assumes requests need no back-pressure.
module pmu_regfile
    import pmu_regs_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int EVT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        id_code,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_opc2,
    input  logic [31:0]        req_wdata,
    input  logic [NUM_CNT-1:0] cnt_ovf_set,
    input  logic               cyc_ovf_set,
    output logic               rsp_valid,
    output logic               rsp_undef,
    output logic [31:0]        rsp_rdata
);

    localparam int PAD_W = DATA_W - EVT_W;

    pmu_sel_e          sel;
    logic              trap;
    logic              wr_en;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] ovf_q;
    logic [EVT_W-1:0]  evt_q;
    logic              uen_q;
    logic [DATA_W-1:0] rd_mux;

    pmu_decode u_decode (
        .crm  (req_crm),
        .opc2 (req_opc2),
        .sel  (sel)
    );

    pmu_access_check u_check (
        .sel      (sel),
        .is_write (req_write),
        .is_user  (req_user),
        .uen      (uen_q),
        .trap     (trap)
    );

    // Purpose: a write commits only when a request is present and not trapped
    always_comb begin
        wr_en = req_valid && req_write && !trap;
    end

    pmu_state #(
        .NUM_CNT (NUM_CNT),
        .EVT_W   (EVT_W)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_code     (id_code),
        .wr_en       (wr_en),
        .sel         (sel),
        .wdata       (req_wdata),
        .cnt_ovf_set (cnt_ovf_set),
        .cyc_ovf_set (cyc_ovf_set),
        .ctrl_q      (ctrl_q),
        .en_q        (en_q),
        .ovf_q       (ovf_q),
        .evt_q       (evt_q),
        .uen_q       (uen_q)
    );

    // Purpose: read data selection; writes and traps return zero
    always_comb begin
        rd_mux = '0;
        if (!req_write && !trap) begin
            case (sel)
                SEL_CTRL:             rd_mux = ctrl_q;
                SEL_ENSET, SEL_ENCLR: rd_mux = en_q;
                SEL_OVF:              rd_mux = ovf_q;
                SEL_EVTYPE:           rd_mux = {{PAD_W{1'b0}}, evt_q};
                SEL_UEN:              rd_mux = {{(DATA_W-1){1'b0}}, uen_q};
                default:              rd_mux = '0;
            endcase
        end
    end

    // Purpose: register the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_undef <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_undef <= req_valid && trap;
            rsp_rdata <= req_valid ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/pmu_regfile_chk.sv
// Module: cycle-level checker for pmu_regfile, attached with bind.
// Assumes the top's internal register outputs are visible by name.
module pmu_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_user,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_opc2,
    input logic        cyc_ovf_set,
    input logic        rsp_valid,
    input logic        rsp_undef,
    input logic [31:0] rsp_rdata,
    input logic [31:0] ctrl_q,
    input logic [31:0] en_q,
    input logic [31:0] ovf_q,
    input logic        uen_q
);

    // R1
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1
    undef_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> rsp_valid);

    // R4
    trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> rsp_rdata == 32'h0);

    // R4
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_undef && $past(rst_n)) |->
            (ctrl_q == $past(ctrl_q) && en_q == $past(en_q) && uen_q == $past(uen_q)));

    // R2
    user_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && !uen_q && !(req_crm == 4'd14 && req_opc2 == 3'd0))
            |=> rsp_undef);

    // R5
    ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ctrl_q & ~32'h39) == ($past(ctrl_q) & ~32'h39));

    // R8
    hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ovf_set |=> ovf_q[31]);

endmodule

bind pmu_regfile pmu_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_user    (req_user),
    .req_crm     (req_crm),
    .req_opc2    (req_opc2),
    .cyc_ovf_set (cyc_ovf_set),
    .rsp_valid   (rsp_valid),
    .rsp_undef   (rsp_undef),
    .rsp_rdata   (rsp_rdata),
    .ctrl_q      (ctrl_q),
    .en_q        (en_q),
    .ovf_q       (ovf_q),
    .uen_q       (uen_q)
);

// File: tb/pmu_regfile_tb.sv
module pmu_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CNT    = 4;
    localparam logic [31:0] ID = 32'hA5C3_1234;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic               req_user = 1'b0;
    logic [3:0]         req_crm = '0;
    logic [2:0]         req_opc2 = '0;
    logic [31:0]        req_wdata = '0;
    logic [NUM_CNT-1:0] cnt_ovf_set = '0;
    logic               cyc_ovf_set = 1'b0;
    logic               rsp_valid;
    logic               rsp_undef;
    logic [31:0]        rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the registers
    logic [31:0] m_ctrl, m_en, m_ovf;
    logic [7:0]  m_evt;
    logic        m_uen;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_regfile #(.NUM_CNT(NUM_CNT), .EVT_W(8)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_code     (ID),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_user    (req_user),
        .req_crm     (req_crm),
        .req_opc2    (req_opc2),
        .req_wdata   (req_wdata),
        .cnt_ovf_set (cnt_ovf_set),
        .cyc_ovf_set (cyc_ovf_set),
        .rsp_valid   (rsp_valid),
        .rsp_undef   (rsp_undef),
        .rsp_rdata   (rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // register code: 0 ctrl,1 enset,2 enclr,3 ovf,4 swinc,5..7 const,8 evt,9 uen,10 none
    function automatic int reg_code(input logic [3:0] crm, input logic [2:0] opc2);
        if (crm == 4'd12 && opc2 <= 3'd5) return int'(opc2);
        if (crm == 4'd13 && opc2 == 3'd0) return 6;
        if (crm == 4'd13 && opc2 == 3'd1) return 8;
        if (crm == 4'd13 && opc2 == 3'd2) return 7;
        if (crm == 4'd14 && opc2 == 3'd0) return 9;
        return 10;
    endfunction

    function automatic string reg_tag(input int rc);
        case (rc)
            0: return "R5";
            1, 2: return "R6";
            3: return "R7";
            4: return "R11";
            5, 6, 7: return "R10";
            8: return "R9";
            9: return "R3";
            default: return "R12";
        endcase
    endfunction

    function automatic bit exp_trap(input int rc, input bit w, input bit u);
        if (rc == 10) return 1'b1;
        if (rc == 4 && !w) return 1'b1;
        if (rc == 9) return u && w;
        return u && !m_uen;
    endfunction

    function automatic logic [31:0] exp_read(input int rc);
        case (rc)
            0: return m_ctrl;
            1, 2: return m_en;
            3: return m_ovf;
            8: return {24'h0, m_evt};
            9: return {31'h0, m_uen};
            default: return 32'h0;
        endcase
    endfunction

    // one access: drive at a falling edge, sample at the next falling edge
    task automatic access(input bit w, input bit u, input logic [3:0] crm, input logic [2:0] opc2,
                          input logic [31:0] wd, input logic [NUM_CNT-1:0] hset, input bit hcyc);
        int rc;
        bit tr;
        logic [31:0] er;
        rc = reg_code(crm, opc2);
        tr = exp_trap(rc, w, u);
        er = (tr || w) ? 32'h0 : exp_read(rc);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_user = u;
        req_crm = crm; req_opc2 = opc2; req_wdata = wd;
        cnt_ovf_set = hset; cyc_ovf_set = hcyc;
        @(negedge clk);
        check(rsp_valid == 1'b1, "R1 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check(rsp_undef == tr, tr ? (u ? "R2 trap" : reg_tag(rc)) : reg_tag(rc),
              {31'h0, rsp_undef}, {31'h0, tr});
        check(rsp_rdata == er, tr ? "R4 trap data" : reg_tag(rc), rsp_rdata, er);
        req_valid = 1'b0; cnt_ovf_set = '0; cyc_ovf_set = 1'b0;
        if (!tr && w) begin
            case (rc)
                0: m_ctrl = (m_ctrl & ~32'h39) | (wd & 32'h39);
                1: m_en = m_en | (wd & 32'h8000_0000);
                2: m_en = m_en & ~(wd & 32'h8000_0000);
                3: m_ovf = m_ovf & ~wd;
                8: m_evt = wd[7:0];
                9: m_uen = wd[0];
                default: ;
            endcase
        end
        m_ovf = m_ovf | {hcyc, {(31-NUM_CNT){1'b0}}, hset};
    endtask

    task automatic read_all;
        for (int c = 12; c <= 14; c++)
            for (int o = 0; o < 8; o++)
                access(1'b0, 1'b0, 4'(c), 3'(o), 32'h0, '0, 1'b0);
    endtask

    initial begin
        m_ctrl = ID & 32'hFF00_0000; m_en = '0; m_ovf = '0; m_evt = '0; m_uen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 / R1: idle after reset
        check(rsp_valid == 1'b0, "R1 idle", {31'h0, rsp_valid}, 32'h0);
        // R13 / R5: reset state of every register
        read_all();
        // R8: hardware set of every implemented bit
        access(1'b0, 1'b0, 4'd12, 3'd3, 32'h0, '1, 1'b1);
        access(1'b0, 1'b0, 4'd12, 3'd3, 32'h0, '0, 1'b0);
        // R8: set wins over clear on the same bit
        access(1'b1, 1'b0, 4'd12, 3'd3, 32'hFFFF_FFFF, 4'b0010, 1'b0);
        access(1'b0, 1'b0, 4'd12, 3'd3, 32'h0, '0, 1'b0);
        // R7: partial clear
        access(1'b1, 1'b0, 4'd12, 3'd3, 32'h0, 4'b1101, 1'b1);
        access(1'b1, 1'b0, 4'd12, 3'd3, 32'h0000_0005, '0, 1'b0);
        access(1'b0, 1'b0, 4'd12, 3'd3, 32'h0, '0, 1'b0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle gap", {31'h0, rsp_valid}, 32'h0);
        // exhaustive sweep: user-enable state x privilege x direction x index
        for (int ue = 0; ue < 2; ue++) begin
            for (int pass = 0; pass < 2; pass++) begin
                access(1'b1, 1'b0, 4'd14, 3'd0, 32'(ue), '0, 1'b0);
                access(1'b1, 1'b0, 4'd12, 3'd1, 32'hFFFF_FFFF, '0, 1'b0);
                access(1'b1, 1'b0, 4'd12, 3'd3, 32'h0, 4'b1111, 1'b1);
                for (int u = 0; u < 2; u++)
                    for (int w = 0; w < 2; w++)
                        for (int c = 0; c < 16; c++)
                            for (int o = 0; o < 8; o++) begin
                                // skip user-enable writes so the state under test holds
                                if (!(c == 14 && o == 0 && w == 1 && u == 0))
                                    access(w[0], u[0], 4'(c), 3'(o),
                                           (32'h9E37_79B9 * 32'(c * 8 + o + 1)) ^ 32'(pass * 32'h5A5A_A5A5),
                                           '0, 1'b0);
                            end
                read_all();
            end
        end
        // R3: privileged write of user-enable then user read
        access(1'b1, 1'b0, 4'd14, 3'd0, 32'hFFFF_FFFE, '0, 1'b0);
        access(1'b0, 1'b1, 4'd14, 3'd0, 32'h0, '0, 1'b0);
        access(1'b1, 1'b0, 4'd14, 3'd0, 32'h0000_0003, '0, 1'b0);
        access(1'b0, 1'b1, 4'd14, 3'd0, 32'h0, '0, 1'b0);
        read_all();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule